// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns single core-side transfer requests into the pin-level strobe sequence of a small microcontroller external bus. The low address byte and the data byte share one bidirectional port. An address latch strobe tells external logic when to capture the low byte. The upper address byte is driven on its own port. There are three cycle types: a code fetch, which uses a program-store enable strobe, and a data read and a data write, which use a read or a write strobe. Every strobe edge falls on a whole number of oscillator clocks from the start of the cycle.

The core presents a request with its cycle type, a 16-bit address and a write byte. The request is accepted on a clock where `req_ready` is high. The block then runs a 6-clock fetch template or a 12-clock data template. It raises `done` for one clock, and returns the byte sampled from the port on a fetch or a read. `req_ready` is also high in the last clock of a cycle, so requests can follow each other with no idle clock between them.

Top module: `ebus_seq`

## Requirements
- R1: While reset is asserted and after it, until a request is accepted: `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `ad_oe` and `done` are low, and `req_ready` is high.
- R2: In every bus cycle `ale` is high for exactly 2 clocks, starting in the clock after the request is accepted (cycle phases 0 and 1). No other strobe is low while `ale` is high.
- R3: In phases 0 to 2, `ad_oe` is high and `ad_out` carries the low address byte. That is 2 clocks before `ale` falls and 1 clock after. `addr_hi` carries the upper address byte from phase 0 to the end of the cycle.
- R4: On a fetch (`req_kind` = 0), `psen_n` is low for exactly 3 clocks, in phases 3 to 5, which is 1 clock after `ale` falls. `ad_oe` is low from phase 3 to the end of the cycle.
- R5: On a read (`req_kind` = 1, or the reserved code 3, which behaves as a read), `rd_n` is low in phases 5 to 10. On a write (`req_kind` = 2), `wr_n` is low in the same phases. That is 3 clocks after `ale` falls, for 6 clocks. At most one of the three strobes is low at any time.
- R6: On a write, `ad_oe` is low in phase 3 and high in phases 4 to 11 with `ad_out` equal to the write byte. The byte is valid 1 clock before `wr_n` falls and is held 1 clock after it rises. On a read, `ad_oe` is low from phase 3 on.
- R7: The value on `ad_in` is sampled at the clock edge where the cycle's strobe returns high: the end of phase 5 for a fetch, the end of phase 10 for a read. `done` is then high for exactly one clock after that edge, with `rdata` holding the sampled byte. A write also gives a one-clock `done` after its strobe rises, and leaves `rdata` unchanged.
- R8: A fetch lasts 6 clocks and a data cycle 12. With a request waiting, the next `ale` rises in the clock after the last phase, which is 1 clock after a read or write strobe returns high.
- R9: `req_ready` is high when no cycle is running and in the last phase of a cycle, and low in all other phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period is the timing unit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted on this clock edge if valid |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 treated as read |
| req_addr | input | 16 | Full bus address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte sampled on a fetch or read |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / write data out |
| ad_oe | output | 1 | Drive enable for the multiplexed port |
| ad_in | input | 8 | Multiplexed port input value |
| addr_hi | output | 16-8 | Upper address byte |

## Verification
The bench runs single isolated fetches, reads and writes, each followed by idle clocks. This separates the strobe timing within one template from what happens at the cycle boundary. Back-to-back fetch pairs, and mixed read-write-fetch chains with no gaps, show whether the next `ale` and the `done` of the previous cycle land in the right clocks when they overlap. Writes with distinct data bytes and address patterns show whether the port switches from address to data at the right phase. The reserved cycle code checks that it follows the read template.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } bus_kind_e;

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic rd_n;
    logic wr_n;
    logic oe;
    logic sel_wdata;
  } pin_state_t;

  localparam pin_state_t PINS_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1,
                                       wr_n: 1'b1, oe: 1'b0, sel_wdata: 1'b0};

endpackage

// File: rtl/ebus_phase_ctrl.sv
module ebus_phase_ctrl
  import ebus_seq_pkg::*;
#(
  parameter int PW        = 4,
  parameter int FETCH_LEN = 6,
  parameter int DATA_LEN  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  output logic          req_ready,
  output logic          accept,
  output logic          busy_q,
  output bus_kind_e     kind_q,
  output logic [PW-1:0] phase_q,
  output logic          busy_nx,
  output bus_kind_e     kind_nx,
  output logic [PW-1:0] phase_nx
);

  localparam logic [PW-1:0] FETCH_LAST = PW'(FETCH_LEN - 1);
  localparam logic [PW-1:0] DATA_LAST  = PW'(DATA_LEN - 1);

  logic      last_q;
  bus_kind_e kind_in;

  always_comb begin
    kind_in = bus_kind_e'(req_kind);
    if (kind_in == KIND_RSVD) kind_in = KIND_READ;
  end

  assign last_q    = busy_q &&
                     (phase_q == ((kind_q == KIND_FETCH) ? FETCH_LAST : DATA_LAST));
  assign req_ready = !busy_q || last_q;
  assign accept    = req_valid && req_ready;

  always_comb begin
    busy_nx  = busy_q;
    kind_nx  = kind_q;
    phase_nx = phase_q;
    if (accept) begin
      busy_nx  = 1'b1;
      kind_nx  = kind_in;
      phase_nx = '0;
    end else if (last_q) begin
      busy_nx  = 1'b0;
      phase_nx = '0;
    end else if (busy_q) begin
      phase_nx = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      kind_q  <= KIND_FETCH;
      phase_q <= '0;
    end else begin
      busy_q  <= busy_nx;
      kind_q  <= kind_nx;
      phase_q <= phase_nx;
    end
  end

endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
  import ebus_seq_pkg::*;
#(
  parameter int PW        = 4,
  parameter int ALE_W     = 2,
  parameter int ADDR_HOLD = 1,
  parameter int PSEN_W    = 3,
  parameter int STB_GAP   = 3,
  parameter int STB_W     = 6,
  parameter int WD_SETUP  = 1,
  parameter int WD_HOLD   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_nx,
  input  bus_kind_e     kind_nx,
  input  logic [PW-1:0] phase_nx,
  output pin_state_t    pins_q
);

  localparam logic [PW-1:0] ALE_END  = PW'(ALE_W);
  localparam logic [PW-1:0] ADR_END  = PW'(ALE_W + ADDR_HOLD);
  localparam logic [PW-1:0] PS_END   = PW'(ALE_W + ADDR_HOLD + PSEN_W);
  localparam logic [PW-1:0] STB_BEG  = PW'(ALE_W + STB_GAP);
  localparam logic [PW-1:0] STB_END  = PW'(ALE_W + STB_GAP + STB_W);
  localparam logic [PW-1:0] WD_BEG   = PW'(ALE_W + STB_GAP - WD_SETUP);
  localparam logic [PW-1:0] WD_END   = PW'(ALE_W + STB_GAP + STB_W + WD_HOLD);

  pin_state_t pins_nx;
  logic       in_adr, in_psen, in_stb, in_wd;

  always_comb begin
    in_adr  = phase_nx < ADR_END;
    in_psen = (phase_nx >= ADR_END) && (phase_nx < PS_END);
    in_stb  = (phase_nx >= STB_BEG) && (phase_nx < STB_END);
    in_wd   = (phase_nx >= WD_BEG) && (phase_nx < WD_END);
    pins_nx = PINS_IDLE;
    if (busy_nx) begin
      pins_nx.ale = phase_nx < ALE_END;
      pins_nx.oe  = in_adr;
      unique case (kind_nx)
        KIND_FETCH: pins_nx.psen_n = !in_psen;
        KIND_WRITE: begin
          pins_nx.wr_n      = !in_stb;
          pins_nx.oe        = in_adr || in_wd;
          pins_nx.sel_wdata = in_wd;
        end
        default:    pins_nx.rd_n = !in_stb;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_IDLE;
    else        pins_q <= pins_nx;
  end

endmodule

// File: rtl/ebus_read_capture.sv
module ebus_read_capture
  import ebus_seq_pkg::*;
#(
  parameter int PW        = 4,
  parameter int DW        = 8,
  parameter int FETCH_SMP = 5,
  parameter int DATA_SMP  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_q,
  input  bus_kind_e     kind_q,
  input  logic [PW-1:0] phase_q,
  input  logic [DW-1:0] ad_in,
  output logic          done_q,
  output logic [DW-1:0] rdata_q
);

  localparam logic [PW-1:0] F_SMP = PW'(FETCH_SMP);
  localparam logic [PW-1:0] D_SMP = PW'(DATA_SMP);

  logic smp_point, take_data;

  always_comb begin
    smp_point = busy_q &&
                (phase_q == ((kind_q == KIND_FETCH) ? F_SMP : D_SMP));
    take_data = smp_point && (kind_q != KIND_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= smp_point;
      if (take_data) rdata_q <= ad_in;
    end
  end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ALE_W     = 2,
  parameter int ADDR_HOLD = 1,
  parameter int PSEN_W    = 3,
  parameter int STB_GAP   = 3,
  parameter int STB_W     = 6,
  parameter int WD_SETUP  = 1,
  parameter int WD_HOLD   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] addr_hi
);

  localparam int FETCH_LEN = ALE_W + ADDR_HOLD + PSEN_W;
  localparam int DATA_LEN  = ALE_W + STB_GAP + STB_W + WD_HOLD;
  localparam int FETCH_SMP = FETCH_LEN - 1;
  localparam int DATA_SMP  = ALE_W + STB_GAP + STB_W - 1;
  localparam int PW        = $clog2(DATA_LEN + 1);

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          accept, busy_q, busy_nx;
  bus_kind_e     kind_q, kind_nx;
  logic [PW-1:0] phase_q, phase_nx;
  pin_state_t    pins_q, pins_nx_unused;
  logic [AW-1:0] addr_q, addr_src;
  logic [DW-1:0] wdata_q, wdata_src, ad_q, ad_nx;

  assign pins_nx_unused = PINS_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ebus_phase_ctrl #(.PW(PW), .FETCH_LEN(FETCH_LEN), .DATA_LEN(DATA_LEN)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_ready(req_ready), .accept(accept), .busy_q(busy_q), .kind_q(kind_q),
    .phase_q(phase_q), .busy_nx(busy_nx), .kind_nx(kind_nx), .phase_nx(phase_nx)
  );

  ebus_strobe_gen #(.PW(PW), .ALE_W(ALE_W), .ADDR_HOLD(ADDR_HOLD), .PSEN_W(PSEN_W),
                    .STB_GAP(STB_GAP), .STB_W(STB_W), .WD_SETUP(WD_SETUP),
                    .WD_HOLD(WD_HOLD)) stb_i (
    .clk(clk), .rst_n(rst_int_n), .busy_nx(busy_nx), .kind_nx(kind_nx),
    .phase_nx(phase_nx), .pins_q(pins_q)
  );

  ebus_read_capture #(.PW(PW), .DW(DW), .FETCH_SMP(FETCH_SMP), .DATA_SMP(DATA_SMP)) cap_i (
    .clk(clk), .rst_n(rst_int_n), .busy_q(busy_q), .kind_q(kind_q), .phase_q(phase_q),
    .ad_in(ad_in), .done_q(done), .rdata_q(rdata)
  );

  // Request fields held for the running cycle; the port value is chosen
  // from the incoming request on the accepting edge.
  always_comb begin
    addr_src  = accept ? req_addr  : addr_q;
    wdata_src = accept ? req_wdata : wdata_q;
    ad_nx     = ad_q;
    if (busy_nx) ad_nx = stb_i.pins_nx.sel_wdata ? wdata_src : addr_src[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      ad_q    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      ad_q <= ad_nx;
    end
  end

  assign ale     = pins_q.ale;
  assign psen_n  = pins_q.psen_n;
  assign rd_n    = pins_q.rd_n;
  assign wr_n    = pins_q.wr_n;
  assign ad_oe   = pins_q.oe;
  assign ad_out  = ad_q;
  assign addr_hi = addr_q[AW-1:DW];

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic done
);

  assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> (ale ##1 !ale));

  assert_ale_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  assert_port_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !ad_oe);

  assert_wdata_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind ebus_seq ebus_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .ad_oe(ad_oe), .done(done)
);

// File: tb/ebus_seq_tb_top.sv
`timescale 1ns/1ps
module ebus_seq_tb_top;

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wd;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        done;
  logic [7:0]  rdata;
  logic        ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0]  ad_out, ad_in, addr_hi;
  logic [7:0]  lat_lo;

  int checks = 0;
  int errors = 0;
  item_t q[$];
  bit mon_on = 0;

  always #2 clk = ~clk;

  ebus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi)
  );

  // External memory model: latch the low byte when ale falls.
  always @(negedge ale) lat_lo <= ad_out;

  function automatic logic [7:0] mem_val(input logic [15:0] a, input bit code);
    return a[7:0] ^ {a[14:8], a[15]} ^ (code ? 8'hC3 : 8'h5A);
  endfunction

  assign ad_in = !psen_n ? mem_val({addr_hi, lat_lo}, 1'b1) :
                 !rd_n   ? mem_val({addr_hi, lat_lo}, 1'b0) : 8'hFF;

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", what, $time, act, exp);
    end
  endtask

  function automatic int eff_kind(input logic [1:0] k);
    return (k == 2'd3) ? 1 : int'(k);
  endfunction

  function automatic int cyc_len(input logic [1:0] k);
    return (eff_kind(k) == 0) ? 6 : 12;
  endfunction

  // Monitor: tracks the cycle phase from ale and compares every pin with the template.
  int          ph = -1;
  item_t       cur;
  logic        ale_prev = 1'b0;
  bit          done_due = 0;
  bit          due_wr = 0;
  logic [7:0]  due_data;

  always @(negedge clk) begin
    if (mon_on) begin
      if (done_due) begin
        chk(done === 1'b1, "R7 done pulse", {31'd0, done}, 1);
        if (!due_wr) chk(rdata === due_data, "R7 sampled byte", {24'd0, rdata}, {24'd0, due_data});
        done_due = 0;
      end else begin
        chk(done === 1'b0, "R7 done quiet", {31'd0, done}, 0);
      end

      if (ale && !ale_prev) begin
        if (ph >= 0) chk(ph + 1 == cyc_len(cur.kind), "R8 cycle length", ph + 1, cyc_len(cur.kind));
        if (q.size() == 0) begin
          chk(0, "R2 unexpected ale", 1, 0);
          ph = -1;
        end else begin
          cur = q.pop_front();
          ph = 0;
        end
      end else if (ph >= 0) begin
        ph++;
        if (ph >= cyc_len(cur.kind)) ph = -1;
      end
      ale_prev = ale;

      if (ph >= 0) begin
        automatic int  k     = eff_kind(cur.kind);
        automatic bit  e_ale = ph < 2;
        automatic bit  e_ps  = !(k == 0 && ph >= 3 && ph <= 5);
        automatic bit  e_rd  = !(k == 1 && ph >= 5 && ph <= 10);
        automatic bit  e_wr  = !(k == 2 && ph >= 5 && ph <= 10);
        automatic bit  e_oe  = (ph < 3) || (k == 2 && ph >= 4);
        chk(ale === e_ale, "R2 ale level", {31'd0, ale}, {31'd0, e_ale});
        chk(psen_n === e_ps, "R4 psen_n level", {31'd0, psen_n}, {31'd0, e_ps});
        chk(rd_n === e_rd, "R5 rd_n level", {31'd0, rd_n}, {31'd0, e_rd});
        chk(wr_n === e_wr, "R5 wr_n level", {31'd0, wr_n}, {31'd0, e_wr});
        chk(ad_oe === e_oe, "R6 port drive", {31'd0, ad_oe}, {31'd0, e_oe});
        chk(addr_hi === cur.addr[15:8], "R3 upper address", {24'd0, addr_hi}, {24'd0, cur.addr[15:8]});
        if (ph < 3)
          chk(ad_out === cur.addr[7:0], "R3 low address", {24'd0, ad_out}, {24'd0, cur.addr[7:0]});
        else if (e_oe)
          chk(ad_out === cur.wd, "R6 write byte", {24'd0, ad_out}, {24'd0, cur.wd});
        chk(req_ready === (ph == cyc_len(cur.kind) - 1), "R9 ready in cycle",
            {31'd0, req_ready}, {31'd0, (ph == cyc_len(cur.kind) - 1)});
        if (ph == ((k == 0) ? 5 : 10)) begin
          done_due = 1;
          due_wr   = (k == 2);
          due_data = mem_val(cur.addr, k == 0);
        end
      end else begin
        chk({ale, psen_n, rd_n, wr_n, ad_oe} === 5'b01110, "R1 idle pins",
            {27'd0, ale, psen_n, rd_n, wr_n, ad_oe}, 32'b01110);
        chk(req_ready === 1'b1, "R9 ready idle", {31'd0, req_ready}, 1);
      end
    end
  end

  // Driver: present a request, push its expectation, return after acceptance.
  task automatic do_req(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    item_t it;
    it.kind = k; it.addr = a; it.wd = d;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    q.push_back(it);
    forever begin
      if (req_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic go_idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({ale, psen_n, rd_n, wr_n, ad_oe, done} === 6'b011100, "R1 reset pins",
        {26'd0, ale, psen_n, rd_n, wr_n, ad_oe, done}, 32'b011100);
    chk(req_ready === 1'b1, "R1 reset ready", {31'd0, req_ready}, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;
    go_idle(3);

    do_req(2'd0, 16'h1234, 8'h00); go_idle(4);   // isolated fetch, R4
    do_req(2'd1, 16'hA55A, 8'h00); go_idle(4);   // isolated read, R5 R7
    do_req(2'd2, 16'h0FF0, 8'hC7); go_idle(4);   // isolated write, R6
    do_req(2'd0, 16'h8001, 8'h00);               // back-to-back fetches, R8
    do_req(2'd0, 16'h8002, 8'h00); go_idle(3);
    do_req(2'd1, 16'h3C3C, 8'h00);               // read, write, fetch chain, R8 R9
    do_req(2'd2, 16'hFFFF, 8'h5A);
    do_req(2'd0, 16'h0000, 8'h00); go_idle(4);
    do_req(2'd2, 16'h7E81, 8'h00);               // write of zero then ones, R6
    do_req(2'd2, 16'h7E82, 8'hFF); go_idle(4);
    do_req(2'd3, 16'h4242, 8'h99); go_idle(4);   // reserved code acts as read, R5
    for (int i = 0; i < 6; i++) begin
      do_req(2'(i % 3), 16'(16'h1111 * (i + 1)), 8'(8'h21 * i));
    end
    go_idle(20);

    chk(q.size() == 0, "R2 all cycles seen", q.size(), 0);
    summary();
    $finish;
  end

endmodule